// File: doc/BRIEF.md
# Flash Status Toggle Poller

This block works out, on the host side, when a program or erase operation inside a parallel NOR flash has finished. A start pulse makes it read the device's 8-bit status byte in pairs through a simple request/acknowledge read port. For each pair it compares the chosen toggle bit. It settles on success when the bit stops changing. It settles on failure when the bit keeps changing after the timeout flag has come up. On failure the caller must write the reset command. The block does not build the command sequences, does not time the flash bus, and does not look at a ready/busy pin.

The toggle bit is normally bit 6. A configuration input swaps it for bit 2, which is used for per-sector erase checks. Bit 5 is the timeout flag. When the flag is seen high while the bit is still changing, the block makes one more pair of reads before it judges. Toggling can stop just as the flag rises, so only a change that is still present in that extra pair counts as a failure. A programmable limit on the number of unresolved pairs keeps a stuck device from holding the controller forever. The caller can abort polling at any time. A later start always begins again from the first read of a pair.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, busy, done, ok, reset_req, wdog_fault and rd_req are all 0.
- R2: A start pulse while busy is 0 sets busy in the next cycle and clears done, ok, reset_req and wdog_fault. It also latches sel_bit2 and max_polls. rd_req is high only while busy. A read completes in a cycle in which rd_req and rd_ack are both 1, and rd_data is sampled in that cycle.
- R3: When the toggle bit has the same value in both reads of a pair, the block ends with done=1, ok=1 and reset_req=0, and it issues no further reads.
- R4: When the toggle bit differs between the two reads and bit 5 of the second read is 0, the block starts another pair and gives no result.
- R5: When the toggle bit differs and bit 5 of the second read is 1, the block makes one more pair (the recheck). If the toggle bit is equal in that pair, it ends with done=1 and ok=1.
- R6: If the toggle bit still differs in the recheck pair, the block ends with done=1, ok=0 and reset_req=1, and wdog_fault stays 0.
- R7: With sel_bit2=0 (latched at start) the toggle bit is bit 6 and bit 2 has no effect. With sel_bit2=1 the toggle bit is bit 2 and bit 6 has no effect.
- R8: With max_polls nonzero, the max_polls-th consecutive pair that ends without a verdict (R4 or R5 would apply) ends the run with done=1, ok=0, reset_req=1 and wdog_fault=1. A pass or a fail on that same pair takes priority. max_polls=0 disables the limit.
- R9: abort while busy makes busy and rd_req 0 in the next cycle and gives no result, even if rd_ack is high in the same cycle. The next start begins again from the first read of a pair. abort while idle has no effect.
- R10: done, ok, reset_req and wdog_fault hold their values until the next accepted start. done and busy are never both 1. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin polling (pulse) |
| abort | input | 1 | Abandon polling (pulse) |
| sel_bit2 | input | 1 | 1 selects bit 2 as toggle bit, 0 selects bit 6 |
| max_polls | input | 16 | Limit on unresolved pairs; 0 means no limit |
| rd_req | output | 1 | Status read wanted |
| rd_ack | input | 1 | Read completes this cycle |
| rd_data | input | 8 | Status byte, valid with rd_ack |
| busy | output | 1 | Polling in progress |
| done | output | 1 | Result valid |
| ok | output | 1 | Operation finished successfully |
| reset_req | output | 1 | Caller must write the reset command |
| wdog_fault | output | 1 | Pair limit expired |

## Verification
Two things can happen in the same cycle. The pair limit can expire on the very read that would also resolve the pair, or an abort can arrive together with a read acknowledge. The vector table places a resolving pair, either a pass or a recheck failure, exactly at the max_polls-th pair. The result must then be the verdict and not a watchdog fault. A directed test raises abort in the same cycle as an acknowledged read and checks that the sample is thrown away: after the restart, a pair gives a pass only if the read taken before the abort was discarded.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_RD_FIRST   = 2'd1,
    ST_RD_SECOND  = 2'd2
  } ftp_state_e;

  typedef enum logic [1:0] {
    PV_CONTINUE = 2'd0,
    PV_RECHECK  = 2'd1,
    PV_PASS     = 2'd2,
    PV_FAIL     = 2'd3
  } ftp_verdict_e;

endpackage

// File: rtl/ftp_bit_tap.sv
module ftp_bit_tap #(
  parameter int DATA_W   = 8,
  parameter int MAIN_POS = 6,
  parameter int ALT_POS  = 2,
  parameter int FLAG_POS = 5
) (
  input  logic [DATA_W-1:0] rd_data,
  input  logic              use_alt,
  output logic              tog_bit,
  output logic              flag_bit
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] MAIN_IDX = IDX_W'(MAIN_POS);
  localparam logic [IDX_W-1:0] ALT_IDX  = IDX_W'(ALT_POS);

  logic [IDX_W-1:0] tap_idx;

  always_comb begin
    tap_idx  = use_alt ? ALT_IDX : MAIN_IDX;
    tog_bit  = rd_data[tap_idx];
    flag_bit = rd_data[FLAG_POS];
  end

endmodule

// File: rtl/ftp_pair_judge.sv
module ftp_pair_judge
  import ftp_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         first_en,
  input  logic         tog_bit,
  input  logic         flag_bit,
  input  logic         recheck,
  output ftp_verdict_e verdict
);

  logic first_q;
  logic first_d;

  always_comb begin
    first_d = first_en ? tog_bit : first_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
    end else begin
      first_q <= first_d;
    end
  end

  always_comb begin
    if (first_q == tog_bit) begin
      verdict = PV_PASS;
    end else if (recheck) begin
      verdict = PV_FAIL;
    end else if (flag_bit) begin
      verdict = PV_RECHECK;
    end else begin
      verdict = PV_CONTINUE;
    end
  end

endmodule

// File: rtl/ftp_pair_limit.sv
module ftp_pair_limit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    expire   = step && (limit != '0) && (count_q == (limit - 1'b1));
    count_en = clear || step;
    count_d  = clear ? '0 : (count_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
  import ftp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MAIN_POS = 6,
  parameter int ALT_POS  = 2,
  parameter int FLAG_POS = 5,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              sel_bit2,
  input  logic [CNT_W-1:0]  max_polls,
  output logic              rd_req,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic              reset_req,
  output logic              wdog_fault
);

  ftp_state_e       state_q, state_d;
  logic             recheck_q, recheck_d;
  logic             use_alt_q;
  logic [CNT_W-1:0] limit_q;
  logic             done_q, done_d;
  logic             ok_q, ok_d;
  logic             rreq_q, rreq_d;
  logic             fault_q, fault_d;
  logic             launch;
  logic             rd_fire;
  logic             first_en;
  logic             pair_step;
  logic             expire;
  logic             tog_bit;
  logic             flag_bit;
  ftp_verdict_e     verdict;

  ftp_bit_tap #(
    .DATA_W  (DATA_W),
    .MAIN_POS(MAIN_POS),
    .ALT_POS (ALT_POS),
    .FLAG_POS(FLAG_POS)
  ) u_tap (
    .rd_data (rd_data),
    .use_alt (use_alt_q),
    .tog_bit (tog_bit),
    .flag_bit(flag_bit)
  );

  ftp_pair_judge u_judge (
    .clk     (clk),
    .rst_n   (rst_n),
    .first_en(first_en),
    .tog_bit (tog_bit),
    .flag_bit(flag_bit),
    .recheck (recheck_q),
    .verdict (verdict)
  );

  ftp_pair_limit #(.CNT_W(CNT_W)) u_limit (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (launch),
    .step  (pair_step),
    .limit (limit_q),
    .expire(expire)
  );

  always_comb begin
    launch    = (state_q == ST_IDLE) && start;
    rd_fire   = (state_q != ST_IDLE) && rd_ack && !abort;
    first_en  = rd_fire && (state_q == ST_RD_FIRST);
    pair_step = rd_fire && (state_q == ST_RD_SECOND) &&
                ((verdict == PV_CONTINUE) || (verdict == PV_RECHECK));
  end

  always_comb begin
    state_d   = state_q;
    recheck_d = recheck_q;
    done_d    = done_q;
    ok_d      = ok_q;
    rreq_d    = rreq_q;
    fault_d   = fault_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d   = ST_RD_FIRST;
          recheck_d = 1'b0;
          done_d    = 1'b0;
          ok_d      = 1'b0;
          rreq_d    = 1'b0;
          fault_d   = 1'b0;
        end
      end
      ST_RD_FIRST: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else if (rd_fire) begin
          state_d = ST_RD_SECOND;
        end
      end
      ST_RD_SECOND: begin
        if (abort) begin
          state_d = ST_IDLE;
        end else if (rd_fire) begin
          unique case (verdict)
            PV_PASS: begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
              ok_d    = 1'b1;
            end
            PV_FAIL: begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
              rreq_d  = 1'b1;
            end
            default: begin
              if (expire) begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
                rreq_d  = 1'b1;
                fault_d = 1'b1;
              end else begin
                state_d   = ST_RD_FIRST;
                recheck_d = (verdict == PV_RECHECK);
              end
            end
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      recheck_q <= 1'b0;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
      rreq_q    <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      recheck_q <= recheck_d;
      done_q    <= done_d;
      ok_q      <= ok_d;
      rreq_q    <= rreq_d;
      fault_q   <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_alt_q <= 1'b0;
      limit_q   <= '0;
    end else if (launch) begin
      use_alt_q <= sel_bit2;
      limit_q   <= max_polls;
    end
  end

  always_comb begin
    rd_req     = (state_q != ST_IDLE);
    busy       = (state_q != ST_IDLE);
    done       = done_q;
    ok         = ok_q;
    reset_req  = rreq_q;
    wdog_fault = fault_q;
  end

endmodule

// File: rtl/ftp_checker.sv
module ftp_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic abort,
  input logic rd_req,
  input logic busy,
  input logic done,
  input logic ok,
  input logic reset_req,
  input logic wdog_fault
);

  assert_req_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);

  assert_start_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && !ok && !reset_req && !wdog_fault));

  assert_pass_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (done && !reset_req && !wdog_fault));

  assert_fail_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok) |-> reset_req);

  assert_fault_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_fault |-> (done && reset_req && !ok));

  assert_abort_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy) |=> (!busy && !rd_req && !done));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(ok) && $stable(reset_req) && $stable(wdog_fault)));

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

endmodule

bind flash_toggle_poller ftp_checker u_ftp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .abort     (abort),
  .rd_req    (rd_req),
  .busy      (busy),
  .done      (done),
  .ok        (ok),
  .reset_req (reset_req),
  .wdog_fault(wdog_fault)
);

// File: tb/flash_toggle_poller_test.sv
`timescale 1ns/1ps
module flash_toggle_poller_test;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        abort;
  logic        sel_bit2;
  logic [15:0] max_polls;
  logic        rd_req;
  logic        rd_ack;
  logic [7:0]  rd_data;
  logic        busy;
  logic        done;
  logic        ok;
  logic        reset_req;
  logic        wdog_fault;

  int n_checks;
  int n_fails;
  int cyc_count;

  flash_toggle_poller uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .abort     (abort),
    .sel_bit2  (sel_bit2),
    .max_polls (max_polls),
    .rd_req    (rd_req),
    .rd_ack    (rd_ack),
    .rd_data   (rd_data),
    .busy      (busy),
    .done      (done),
    .ok        (ok),
    .reset_req (reset_req),
    .wdog_fault(wdog_fault)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Status bytes: bit 6 main toggle, bit 2 alternate toggle, bit 5 timeout flag.
  // First read in the lowest byte.
  localparam int NV = 10;
  localparam logic [47:0] V_BYTES [NV] = '{
    48'h000000004040,  // R3 pass at once
    48'h404040004000,  // R4 two unresolved pairs, then pass
    48'h000040406000,  // R5 flag, recheck passes
    48'h000060206000,  // R6 flag, recheck still toggles
    48'h000004440004,  // R7 bit 2 selected, bit 6 change ignored
    48'h000000000004,  // R7 bit 6 selected, bit 2 change ignored
    48'h000040004000,  // R8 limit 2 expires
    48'h000040404000,  // R8 pass on the limit pair wins
    48'h000000006000,  // R8 limit 1 on a recheck entry
    48'h000040006000   // R8 recheck fail on the limit pair wins
  };
  localparam int V_SEL   [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 0};
  localparam int V_LIM   [NV] = '{0, 0, 0, 0, 0, 0, 2, 2, 1, 2};
  localparam int V_READS [NV] = '{2, 6, 4, 4, 4, 2, 4, 4, 2, 4};
  localparam int V_OK    [NV] = '{1, 1, 1, 0, 1, 1, 0, 1, 0, 0};
  localparam int V_RST   [NV] = '{0, 0, 0, 1, 0, 0, 1, 0, 1, 1};
  localparam int V_FLT   [NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 1, 0};

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_poll(input int sel, input int lim, input logic [47:0] bytes,
                          input int extra_start_at, output int nrd, output int finished);
    @(negedge clk);
    sel_bit2  = sel[0];
    max_polls = 16'(lim);
    start     = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    nrd      = 0;
    finished = 0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      if (done) begin
        finished = 1;
        break;
      end
      if (rd_req && nrd < 6) begin
        rd_ack  = 1'b1;
        rd_data = bytes[8*nrd +: 8];
        start   = (nrd == extra_start_at);
        nrd++;
      end else begin
        rd_ack = 1'b0;
        start  = 1'b0;
      end
      @(negedge clk);
    end
    rd_ack = 1'b0;
    start  = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc_count <= cyc_count + 1;
    if (cyc_count > 150000) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc_count, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int nrd;
    int fin;
    n_checks  = 0;
    n_fails   = 0;
    cyc_count = 0;
    rst_n     = 1'b0;
    start     = 1'b0;
    abort     = 1'b0;
    sel_bit2  = 1'b0;
    max_polls = 16'd0;
    rd_ack    = 1'b0;
    rd_data   = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 ok", int'(ok), 0);
    check("R1 reset_req", int'(reset_req), 0);
    check("R1 wdog_fault", int'(wdog_fault), 0);
    check("R1 rd_req", int'(rd_req), 0);

    // Vector table (R3..R8)
    for (int v = 0; v < NV; v++) begin
      run_poll(V_SEL[v], V_LIM[v], V_BYTES[v], -1, nrd, fin);
      check($sformatf("R3-table v%0d finished", v), fin, 1);
      check($sformatf("R4 v%0d read count", v), nrd, V_READS[v]);
      check($sformatf("R5 v%0d ok", v), int'(ok), V_OK[v]);
      check($sformatf("R6 v%0d reset_req", v), int'(reset_req), V_RST[v]);
      check($sformatf("R8 v%0d wdog_fault", v), int'(wdog_fault), V_FLT[v]);
      check($sformatf("R3 v%0d no read after result", v), int'(rd_req), 0);
    end

    // R10 result held, abort while idle has no effect (R9)
    repeat (5) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    @(negedge clk);
    check("R10 done held", int'(done), 1);
    check("R10 reset_req held", int'(reset_req), 1);
    check("R9 idle abort busy", int'(busy), 0);

    // R10 start while busy is ignored
    run_poll(0, 0, 48'h000040406000, 2, nrd, fin);
    check("R10 extra start finished", fin, 1);
    check("R10 extra start reads", nrd, 4);
    check("R10 extra start ok", int'(ok), 1);

    // R2 launch and R9 abort with a coincident acknowledge
    @(negedge clk);
    sel_bit2  = 1'b0;
    max_polls = 16'd0;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", int'(busy), 1);
    check("R2 done cleared", int'(done), 0);
    check("R2 ok cleared", int'(ok), 0);
    check("R2 rd_req", int'(rd_req), 1);
    rd_ack  = 1'b1;
    rd_data = 8'h00;
    @(negedge clk);
    rd_data = 8'h40;
    abort   = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    abort  = 1'b0;
    check("R9 busy after abort", int'(busy), 0);
    check("R9 rd_req after abort", int'(rd_req), 0);
    check("R9 no result", int'(done), 0);
    repeat (2) @(negedge clk);
    run_poll(0, 0, 48'h000000004040, -1, nrd, fin);
    check("R9 resume finished", fin, 1);
    check("R9 resume reads", nrd, 2);
    check("R9 resume ok", int'(ok), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule